// File: doc/BRIEF.md
# Register Access Operation Sequencer

This block runs the operation phase of a memory-management unit's register port. It waits in idle until one of three requests is seen: the unit's own select line with at least one byte strobe, an interrupt-acknowledge cycle while this unit has an interrupt pending, or a global request from another unit on the GO-in line. It then turns on the data transceivers, decodes a 5-bit register-select field together with the read/write line, runs the operation and answers with a data-acknowledge. That acknowledge stays up until the bus master has dropped both byte strobes.

Register writes and writes to the vector register are global operations. The unit that sees its select line becomes master and drives GO-out. A unit that sees GO-in without its own select becomes a slave. A slave performs the write silently and leaves the handshake to the master. Reads and interrupt acknowledges are local. An address that matches no register is a null operation. After the strobes are released, a unit whose address strobe is still asserted can chain a further master or slave operation without passing through idle. Address translation and descriptor contents are outside this block.

Top module: `regop_seq`

## Requirements
- R1: A synchronous reset drives data-acknowledge, transceiver enable and GO-out low, clears every register to 0x0000 and loads the vector register with 0x0F.
- R2: Transceiver enable is asserted while a master or interrupt-acknowledge operation is in progress. It stays low when neither the select line nor an acknowledged pending interrupt is present.
- R3: Interrupt-acknowledge with a pending interrupt and a strobe returns the vector register on data bits 7:0 with bits 15:8 at zero. Interrupt-acknowledge without a pending interrupt produces no response.
- R4: The decode maps select values below NUM_REGS (default 8) to registers and the value VEC_ADDR (default 16) to the vector register. Reading the vector register returns it on bits 7:0. Every other select value is a null operation.
- R5: A register read returns bits 15:8 when the upper strobe is set and bits 7:0 when the lower strobe is set. A lane whose strobe is clear reads as zero.
- R6: A null read returns 0xFF on each strobed lane and acknowledges. A null write acknowledges and changes no register.
- R7: Writes are qualified per lane. A write with only the upper strobe leaves bits 7:0 of the register unchanged. The vector register takes only the lower lane.
- R8: Data-acknowledge stays asserted until both strobes are negated. Data-acknowledge and transceiver enable then fall together.
- R9: A master register or vector write asserts GO-out. Reads and interrupt acknowledges never assert it.
- R10: GO-in with a strobe and no select makes the unit a slave. The slave performs the write but asserts none of data-acknowledge, transceiver enable or GO-out.
- R11: After release with the address strobe still asserted, a new select or GO-in request starts at once. An interrupt-acknowledge waits until the address strobe is negated.
- R12: Strobe, select, GO-in, address-strobe and interrupt inputs pass through a two-stage synchronizer. Data-acknowledge first appears at the fifth falling clock edge after a strobe is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_i | input | 1 | Chip select of this unit |
| as_i | input | 1 | Address strobe |
| ustrb_i | input | 1 | Upper byte strobe |
| lstrb_i | input | 1 | Lower byte strobe |
| iack_i | input | 1 | Interrupt-acknowledge cycle |
| irq_i | input | 1 | Interrupt pending at this unit |
| go_in_i | input | 1 | Global request from another unit |
| rs_i | input | 5 | Register-select field |
| rd_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero while transceivers are off |
| xcvr_en_o | output | 1 | Data transceiver enable |
| dack_o | output | 1 | Data acknowledge |
| go_out_o | output | 1 | Global request to other units |

## Verification
The hardest situation to reach is the chained state. In that state the strobes have been released but the address strobe is still high. The unit must then accept a select or GO-in request straight away while holding back an interrupt acknowledge. The stimulus keeps the address strobe high across one complete write handshake, raises interrupt-acknowledge and waits several cycles to confirm there is no response, then drops the address strobe and expects the vector. A second hard case is the split release: the upper strobe is dropped alone while acknowledge is held, before the lower strobe follows.

// File: rtl/regop_pkg.sv
package regop_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_DECODE, ST_EXECUTE, ST_ACK, ST_WAIT_REL
   } state_e;

   typedef enum logic [1:0] {
      ROLE_MASTER, ROLE_SLAVE, ROLE_IACK
   } role_e;

   typedef enum logic [2:0] {
      OP_IACK, OP_REG_RD, OP_REG_WR, OP_VEC_RD, OP_VEC_WR, OP_NULL_RD, OP_NULL_WR
   } op_e;
endpackage

// File: rtl/regop_sync.sv
module regop_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("regop_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/regop_decode.sv
module regop_decode
   import regop_pkg::*;
#(
   parameter int RS_W     = 5,
   parameter int NUM_REGS = 8,
   parameter int VEC_ADDR = 16
) (
   input  logic [RS_W-1:0] rs,
   input  logic            rd,
   input  role_e           role,
   output op_e             op,
   output logic            global_op
);
   logic is_reg, is_vec;

   assign is_reg = int'(rs) < NUM_REGS;
   assign is_vec = rs == RS_W'(VEC_ADDR);

   always_comb begin
      if (role == ROLE_IACK)      op = OP_IACK;
      else if (is_reg)            op = rd ? OP_REG_RD : OP_REG_WR;
      else if (is_vec)            op = rd ? OP_VEC_RD : OP_VEC_WR;
      else                        op = rd ? OP_NULL_RD : OP_NULL_WR;
      // a slave takes part in writes only; its reads are silent
      if (role == ROLE_SLAVE && rd) op = OP_NULL_RD;
   end

   assign global_op = (op == OP_REG_WR) || (op == OP_VEC_WR);
endmodule

// File: rtl/regop_regfile.sv
module regop_regfile #(
   parameter int         NUM_REGS  = 8,
   parameter int         IDX_W     = 3,
   parameter logic [7:0] RESET_VEC = 8'h0F
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we_hi,
   input  logic             we_lo,
   input  logic [IDX_W-1:0] idx,
   input  logic [15:0]      wdata,
   output logic [15:0]      rdata,
   input  logic             vec_we,
   input  logic [7:0]       vec_wdata,
   output logic [7:0]       vec_q
);
   logic [15:0] regs [NUM_REGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
         vec_q <= RESET_VEC;
      end else begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (we_hi && idx == IDX_W'(i)) regs[i][15:8] <= wdata[15:8];
            if (we_lo && idx == IDX_W'(i)) regs[i][7:0]  <= wdata[7:0];
         end
         if (vec_we) vec_q <= vec_wdata;
      end
   end

   assign rdata = (int'(idx) < NUM_REGS) ? regs[idx] : '0;
endmodule

// File: rtl/regop_seq.sv
module regop_seq
   import regop_pkg::*;
#(
   parameter int         RS_W      = 5,
   parameter int         NUM_REGS  = 8,
   parameter int         VEC_ADDR  = 16,
   parameter int         SYNC_STG  = 2,
   parameter logic [7:0] RESET_VEC = 8'h0F
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            sel_i,
   input  logic            as_i,
   input  logic            ustrb_i,
   input  logic            lstrb_i,
   input  logic            iack_i,
   input  logic            irq_i,
   input  logic            go_in_i,
   input  logic [RS_W-1:0] rs_i,
   input  logic            rd_i,
   input  logic [15:0]     wdata_i,
   output logic [15:0]     rdata_o,
   output logic            xcvr_en_o,
   output logic            dack_o,
   output logic            go_out_o
);
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int N_SYNC = 7;

   generate
      if (NUM_REGS < 2 || NUM_REGS > 2**RS_W) begin : g_bad_regs
         $error("regop_seq: NUM_REGS out of range");
      end
      if (VEC_ADDR < NUM_REGS || VEC_ADDR >= 2**RS_W) begin : g_bad_vec
         $error("regop_seq: VEC_ADDR must lie above the registers");
      end
   endgenerate

   // synchronized control inputs
   logic s_sel, s_as, s_u, s_l, s_iack, s_irq, s_go;

   regop_sync #(.W(N_SYNC), .STAGES(SYNC_STG)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({sel_i, as_i, ustrb_i, lstrb_i, iack_i, irq_i, go_in_i}),
      .q   ({s_sel, s_as, s_u, s_l, s_iack, s_irq, s_go})
   );

   logic any_strb, start_m, start_s, start_i;
   assign any_strb = s_u | s_l;
   assign start_i  = s_iack & s_irq & any_strb;
   assign start_m  = s_sel & any_strb;
   assign start_s  = s_go & any_strb & ~s_sel;

   state_e            state;
   role_e             role;
   op_e               op_q, dec_op;
   logic              dec_glob, glob_q, released, lane_u, lane_l, rd_q;
   logic [RS_W-1:0]   rs_q;
   logic [15:0]       wd_q, rdata_q, reg_rdata;
   logic [7:0]        vec_q;

   regop_decode #(.RS_W(RS_W), .NUM_REGS(NUM_REGS), .VEC_ADDR(VEC_ADDR)) u_dec (
      .rs        (rs_q),
      .rd        (rd_q),
      .role      (role),
      .op        (dec_op),
      .global_op (dec_glob)
   );

   logic exec, we_hi, we_lo, vec_we;
   assign exec   = state == ST_EXECUTE;
   assign we_hi  = exec && op_q == OP_REG_WR && lane_u;
   assign we_lo  = exec && op_q == OP_REG_WR && lane_l;
   assign vec_we = exec && op_q == OP_VEC_WR && lane_l;

   regop_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .RESET_VEC(RESET_VEC)) u_rf (
      .clk       (clk),
      .rst       (rst),
      .we_hi     (we_hi),
      .we_lo     (we_lo),
      .idx       (rs_q[IDX_W-1:0]),
      .wdata     (wd_q),
      .rdata     (reg_rdata),
      .vec_we    (vec_we),
      .vec_wdata (wd_q[7:0]),
      .vec_q     (vec_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         role     <= ROLE_MASTER;
         op_q     <= OP_NULL_RD;
         glob_q   <= 1'b0;
         released <= 1'b0;
         lane_u   <= 1'b0;
         lane_l   <= 1'b0;
         rd_q     <= 1'b1;
         rs_q     <= '0;
         wd_q     <= '0;
         rdata_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               released <= 1'b0;
               if (start_i || start_m || start_s) begin
                  role   <= start_i ? ROLE_IACK : (start_m ? ROLE_MASTER : ROLE_SLAVE);
                  lane_u <= s_u;
                  lane_l <= s_l;
                  rs_q   <= rs_i;
                  rd_q   <= rd_i;
                  wd_q   <= wdata_i;
                  state  <= ST_DECODE;
               end
            end
            ST_DECODE: begin
               op_q   <= dec_op;
               glob_q <= dec_glob;
               state  <= ST_EXECUTE;
            end
            ST_EXECUTE: begin
               case (op_q)
                  OP_IACK, OP_VEC_RD: rdata_q <= {8'h00, vec_q};
                  OP_REG_RD:  rdata_q <= {lane_u ? reg_rdata[15:8] : 8'h00,
                                          lane_l ? reg_rdata[7:0]  : 8'h00};
                  OP_NULL_RD: rdata_q <= {lane_u ? 8'hFF : 8'h00,
                                          lane_l ? 8'hFF : 8'h00};
                  default:    rdata_q <= '0;
               endcase
               state <= ST_ACK;
            end
            ST_ACK: state <= ST_WAIT_REL;
            ST_WAIT_REL: begin
               if (!any_strb) begin
                  released <= 1'b1;
                  if (!s_as) state <= ST_IDLE;
               end else if (released && !s_as) begin
                  state <= ST_IDLE;
               end else if (released && (start_m || start_s)) begin
                  role     <= start_m ? ROLE_MASTER : ROLE_SLAVE;
                  lane_u   <= s_u;
                  lane_l   <= s_l;
                  rs_q     <= rs_i;
                  rd_q     <= rd_i;
                  wd_q     <= wdata_i;
                  released <= 1'b0;
                  state    <= ST_DECODE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic active;
   assign active    = state != ST_IDLE && !released && role != ROLE_SLAVE;
   assign xcvr_en_o = active;
   assign dack_o    = active && (state == ST_ACK || state == ST_WAIT_REL);
   assign go_out_o  = role == ROLE_MASTER && !released && glob_q &&
                      (state == ST_EXECUTE || state == ST_ACK || state == ST_WAIT_REL);
   assign rdata_o   = active ? rdata_q : '0;
endmodule

// File: rtl/regop_seq_chk.sv
module regop_seq_chk (
   input logic clk,
   input logic rst,
   input logic xcvr_en_o,
   input logic dack_o,
   input logic go_out_o
);
   // R8
   ack_needs_xcvr_chk: assert property (@(posedge clk) disable iff (rst)
      dack_o |-> xcvr_en_o);

   // R8
   release_together_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(xcvr_en_o) |-> !dack_o);

   // R8
   xcvr_before_ack_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(dack_o) |-> $past(xcvr_en_o));

   // R9
   go_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
      go_out_o |-> xcvr_en_o);

   // R1
   quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!dack_o && !xcvr_en_o && !go_out_o));
endmodule

bind regop_seq regop_seq_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .xcvr_en_o (xcvr_en_o),
   .dack_o    (dack_o),
   .go_out_o  (go_out_o)
);

// File: tb/tb_regop_seq.sv
module tb_regop_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sel_i = 0, as_i = 0, ustrb_i = 0, lstrb_i = 0;
   logic        iack_i = 0, irq_i = 0, go_in_i = 0, rd_i = 1;
   logic [4:0]  rs_i = '0;
   logic [15:0] wdata_i = '0;
   logic [15:0] rdata_o;
   logic        xcvr_en_o, dack_o, go_out_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   regop_seq dut (
      .clk(clk), .rst(rst), .sel_i(sel_i), .as_i(as_i), .ustrb_i(ustrb_i),
      .lstrb_i(lstrb_i), .iack_i(iack_i), .irq_i(irq_i), .go_in_i(go_in_i),
      .rs_i(rs_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
      .xcvr_en_o(xcvr_en_o), .dack_o(dack_o), .go_out_o(go_out_o)
   );

   task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   logic        acked, go_seen, x_seen;
   logic [15:0] rdv;
   int          lat;

   task automatic run_op(input logic c_sel, c_go, c_iack, c_irq, c_u, c_l, c_rd,
                         input logic [4:0] c_rs, input logic [15:0] c_wd);
      @(negedge clk);
      sel_i = c_sel; go_in_i = c_go; iack_i = c_iack; irq_i = c_irq;
      rd_i = c_rd; rs_i = c_rs; wdata_i = c_wd; ustrb_i = c_u; lstrb_i = c_l;
      acked = 0; go_seen = 0; x_seen = 0; rdv = '0; lat = 0;
      for (int i = 0; i < 15 && !acked; i++) begin
         @(negedge clk);
         if (go_out_o)  go_seen = 1;
         if (xcvr_en_o) x_seen = 1;
         if (dack_o) begin acked = 1; rdv = rdata_o; lat = i + 1; end
      end
      @(negedge clk);
      ustrb_i = 0; lstrb_i = 0; sel_i = 0; go_in_i = 0; iack_i = 0; irq_i = 0;
      for (int i = 0; i < 15 && (dack_o || xcvr_en_o); i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!dack_o && !xcvr_en_o && !go_out_o, "R1 outputs low", {13'b0, dack_o, xcvr_en_o, go_out_o}, 16'h0);
      run_op(0, 0, 1, 1, 0, 1, 1, 5'd0, 16'h0);
      chk(acked && rdv == 16'h000F, "R1 reset vector via R3", rdv, 16'h000F);
      run_op(1, 0, 0, 0, 1, 1, 1, 5'd3, 16'h0);
      chk(rdv == 16'h0000, "R1 register cleared", rdv, 16'h0000);
      chk(lat == 5, "R12 ack latency", 16'(lat), 16'd5);
   endtask

   task automatic t_write_read;
      run_op(1, 0, 0, 0, 1, 1, 0, 5'd2, 16'hA55A);
      chk(acked && x_seen, "R2 xcvr and ack on write", {14'b0, acked, x_seen}, 16'h3);
      chk(go_seen, "R9 go_out on global write", {15'b0, go_seen}, 16'h1);
      run_op(1, 0, 0, 0, 1, 1, 1, 5'd2, 16'h0);
      chk(rdv == 16'hA55A, "R4 register read", rdv, 16'hA55A);
      chk(!go_seen, "R9 no go_out on read", {15'b0, go_seen}, 16'h0);
      run_op(1, 0, 0, 0, 0, 1, 1, 5'd2, 16'h0);
      chk(rdv == 16'h005A, "R5 lower lane only", rdv, 16'h005A);
      run_op(1, 0, 0, 0, 1, 0, 1, 5'd2, 16'h0);
      chk(rdv == 16'hA500, "R5 upper lane only", rdv, 16'hA500);
      run_op(1, 0, 0, 0, 1, 0, 0, 5'd2, 16'h1234);
      run_op(1, 0, 0, 0, 1, 1, 1, 5'd2, 16'h0);
      chk(rdv == 16'h125A, "R7 upper-only write", rdv, 16'h125A);
   endtask

   task automatic t_null;
      run_op(1, 0, 0, 0, 1, 1, 1, 5'd20, 16'h0);
      chk(acked && rdv == 16'hFFFF, "R6 null read both lanes", rdv, 16'hFFFF);
      run_op(1, 0, 0, 0, 0, 1, 1, 5'd9, 16'h0);
      chk(rdv == 16'h00FF, "R6 null read lower lane", rdv, 16'h00FF);
      run_op(1, 0, 0, 0, 1, 1, 0, 5'd20, 16'h0BAD);
      chk(acked && !go_seen, "R6 null write acks locally", {14'b0, acked, go_seen}, 16'h2);
      run_op(1, 0, 0, 0, 1, 1, 1, 5'd2, 16'h0);
      chk(rdv == 16'h125A, "R6 null write no effect", rdv, 16'h125A);
   endtask

   task automatic t_vector;
      run_op(1, 0, 0, 0, 1, 1, 0, 5'd16, 16'hEE47);
      chk(go_seen, "R9 vector write global", {15'b0, go_seen}, 16'h1);
      run_op(1, 0, 0, 0, 1, 1, 1, 5'd16, 16'h0);
      chk(rdv == 16'h0047, "R4 R7 vector read low lane", rdv, 16'h0047);
      run_op(0, 0, 1, 1, 1, 0, 1, 5'd0, 16'h0);
      chk(acked && rdv == 16'h0047 && !go_seen, "R3 iack vector", rdv, 16'h0047);
      run_op(0, 0, 1, 0, 1, 1, 1, 5'd0, 16'h0);
      chk(!acked && !x_seen, "R3 R2 iack without irq ignored", {14'b0, acked, x_seen}, 16'h0);
   endtask

   task automatic t_slave;
      run_op(0, 1, 0, 0, 1, 1, 0, 5'd5, 16'hBEEF);
      chk(!acked && !x_seen && !go_seen, "R10 slave silent", {13'b0, acked, x_seen, go_seen}, 16'h0);
      run_op(1, 0, 0, 0, 1, 1, 1, 5'd5, 16'h0);
      chk(rdv == 16'hBEEF, "R10 slave write applied", rdv, 16'hBEEF);
   endtask

   task automatic t_release;
      logic held;
      @(negedge clk);
      sel_i = 1; rd_i = 1; rs_i = 5'd5; ustrb_i = 1; lstrb_i = 1;
      for (int i = 0; i < 15 && !dack_o; i++) @(negedge clk);
      ustrb_i = 0;
      repeat (6) @(negedge clk);
      held = dack_o;
      chk(held, "R8 ack held with lower strobe", {15'b0, held}, 16'h1);
      lstrb_i = 0; sel_i = 0;
      repeat (5) @(negedge clk);
      chk(!dack_o && !xcvr_en_o, "R8 released", {14'b0, dack_o, xcvr_en_o}, 16'h0);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_chain;
      logic early;
      @(negedge clk); as_i = 1;
      run_op(1, 0, 0, 0, 1, 1, 0, 5'd6, 16'h6666);
      run_op(1, 0, 0, 0, 1, 1, 1, 5'd6, 16'h0);
      chk(acked && rdv == 16'h6666, "R11 chained master op", rdv, 16'h6666);
      @(negedge clk);
      iack_i = 1; irq_i = 1; lstrb_i = 1;
      early = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (dack_o) early = 1;
      end
      chk(!early, "R11 iack deferred while as held", {15'b0, early}, 16'h0);
      as_i = 0;
      acked = 0;
      for (int i = 0; i < 15 && !acked; i++) begin
         @(negedge clk);
         if (dack_o) begin acked = 1; rdv = rdata_o; end
      end
      chk(acked && rdv == 16'h0047, "R11 iack after as drops", rdv, 16'h0047);
      iack_i = 0; irq_i = 0; lstrb_i = 0;
      repeat (6) @(negedge clk);
   endtask

   logic done = 0;

   initial begin
      repeat (4) @(negedge clk);
      rst = 0;
      t_reset();
      t_write_read();
      t_null();
      t_vector();
      t_slave();
      t_release();
      t_chain();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule